// File: doc/BRIEF.md
# USB Host Controller Register File

This block is the software-visible register file of a two-port USB 1.1 host controller. It occupies a 32-byte I/O window that can be accessed with byte, word or dword cycles. It holds the command word, the status flags, the interrupt enables, the frame counter, the frame-list base address and the start-of-frame timing byte. It also holds one control/status word for each root port.

The frame engine reports interrupt causes and error conditions through set-only event inputs. The root ports report device arrival (with a low-speed flag) and device removal. The block combines status flags with their enables into a registered level interrupt. It presents the run flag and the timing registers to the frame engine, and it issues one-cycle bus-reset pulses toward attached devices.

Two features make the block more than a plain register bank. A hidden two-bit cause latch records which completion cause set the USB-interrupt flag, and only that latch is gated by its own enable. The port words also mix three kinds of field: bits that hold their value, bits that software writes, and bits that software clears by writing a one.

Top module: `usbh_regfile`

## Requirements
- R1: After reset the block reads as follows: command 0x0000, status 0x0000, enables 0x0000, frame number 0, base 0, start-of-frame byte 64, every port word 0x0080. IRQ is low.
- R2: A word write to 0x00 stores the value, and `run_o` follows bit 0. If bit 1 (controller reset) or bit 2 (global reset) is set in the write, the value is not stored and every register returns to its R1 value.
- R3: A command write with bit 2 set pulses `port_bus_reset_o` for one cycle on every port that has a device present. After any command reset, a port with a device present reads as freshly attached: connect bits set, and the low-speed bit set from that device's speed.
- R4: Status at 0x02 has six bits, and writing a 1 to a bit clears it. `flag_set_i[k]` sets status bit k+1: bit 1 error, bit 2 resume, bit 3 host-system error, bit 4 process error, bit 5 halted. Any bit of `cause_set_i` sets status bit 0.
- R5: `cause_set_i[0]` (completion) and `cause_set_i[1]` (short packet) set a hidden two-bit latch. The latch clears only when a status write has bit 0 set.
- R6: One cycle after the registers change, IRQ is high exactly when one of these holds: latch bit 0 with enable bit 2; latch bit 1 with enable bit 3; status bit 1 with enable bit 0; status bit 2 with enable bit 1; status bit 3; status bit 4. The enable register at 0x04 keeps bits 3..0, and its upper bits read as zero.
- R7: Status bits 3 and 4 raise IRQ even when all enables are zero.
- R8: The frame number at 0x06 is 11 bits wide. A write changes it only while status bit 5 is set, and the value is truncated to 11 bits.
- R9: The frame-list base is written and read as a dword at 0x08. Its low 12 bits always read as zero.
- R10: The start-of-frame byte is written and read with byte cycles at 0x0C.
- R11: A word write to port slot n (address 0x10+2n) keeps bits 0, 1 and 3..8 and takes all other bits from the data. Bits 1 and 3 are then cleared where the data holds a 1.
- R12: A port write that takes bit 9 from 0 to 1 pulses that port's `port_bus_reset_o` for one cycle, but only if a device is present. There is no pulse if bit 9 was already set or if no device is present.
- R13: On an attach event, the port sets bits 0 and 1 if bit 0 was clear, and it always copies the speed flag into bit 8. On a detach event, if bit 2 (enable) is set, the port clears bit 2 and sets bit 3.
- R14: A word read of an undefined offset, or of a port slot at or beyond NUM_PORTS, returns 0xFF7F. A dword read other than 0x08 returns 0xFFFFFFFF. A byte read other than 0x0C returns 0xFF. Writes to unimplemented port slots have no effect. Reads return data one cycle after `bus_rd`. Size codes are 00 byte, 01 word and 10 dword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 00 byte, 01 word, 10 dword |
| bus_addr | input | 5 | Byte offset in the window |
| bus_wdata | input | 32 | Write data, right-aligned |
| rd_data_o | output | 32 | Registered read data |
| cause_set_i | input | 2 | Completion / short-packet interrupt causes |
| flag_set_i | input | 5 | Set pulses for status bits 1..5 |
| attach_i | input | NUM_PORTS | Device arrival per port |
| attach_low_i | input | NUM_PORTS | Arriving device is low speed |
| detach_i | input | NUM_PORTS | Device removal per port |
| irq_o | output | 1 | Registered interrupt level |
| run_o | output | 1 | Run flag (command bit 0) |
| frame_num_o | output | FRNUM_W | Frame number |
| frame_base_o | output | 32 | Frame-list base address |
| sof_timing_o | output | SOF_W | Start-of-frame timing byte |
| port_bus_reset_o | output | NUM_PORTS | One-cycle bus-reset pulse per port |

## Verification
The bench builds the block with its default parameters: two root ports, an 11-bit frame number and 4 KiB base alignment. With only two ports, six of the eight port slots are unimplemented, so undefined-slot reads and ignored writes can be reached through plain addresses. With the 11-bit frame number, a write of 0xFFFF shows the truncation directly. The two ports are driven differently: one is left without a device and one is given a device that changes speed. This exercises reset re-attachment and the per-port pulse gating on both branches.

// File: rtl/usbh_regfile_pkg.sv
package usbh_regfile_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10
  } bus_size_e;

  localparam logic [4:0] OFS_CMD  = 5'h00;
  localparam logic [4:0] OFS_STS  = 5'h02;
  localparam logic [4:0] OFS_IEN  = 5'h04;
  localparam logic [4:0] OFS_FRN  = 5'h06;
  localparam logic [4:0] OFS_BASE = 5'h08;
  localparam logic [4:0] OFS_SOF  = 5'h0C;

  localparam logic [15:0] PORT_KEEP  = 16'h01FB;
  localparam logic [15:0] PORT_W1C   = 16'h000A;
  localparam logic [15:0] PORT_IDLE  = 16'h0080;
  localparam logic [15:0] WORD_UNDEF = 16'hFF7F;

  localparam int PB_CONN     = 0;
  localparam int PB_CONN_CHG = 1;
  localparam int PB_EN       = 2;
  localparam int PB_EN_CHG   = 3;
  localparam int PB_LOW      = 8;
  localparam int PB_RST      = 9;

  // Apply a device-arrival event to a port control word.
  function automatic logic [15:0] port_on_attach(logic [15:0] v, logic low);
    logic [15:0] r;
    r = v;
    if (!r[PB_CONN]) begin
      r[PB_CONN]     = 1'b1;
      r[PB_CONN_CHG] = 1'b1;
    end
    r[PB_LOW] = low;
    return r;
  endfunction

endpackage

// File: rtl/usbh_root_port.sv
module usbh_root_port
  import usbh_regfile_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        soft_rst,
  input  logic        greset,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        attach,
  input  logic        attach_low,
  input  logic        detach,
  output logic [15:0] ctrl_o,
  output logic        bus_reset_o
);

  logic [15:0] ctrl_q, ctrl_d;
  logic        present_q, low_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = (ctrl_q & PORT_KEEP) | (wdata & ~PORT_KEEP);
      ctrl_d = ctrl_d & ~(wdata & PORT_W1C);
    end
    if (attach) begin
      ctrl_d = port_on_attach(ctrl_d, attach_low);
    end else if (detach && ctrl_d[PB_EN]) begin
      ctrl_d[PB_EN]     = 1'b0;
      ctrl_d[PB_EN_CHG] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= PORT_IDLE;
      present_q   <= 1'b0;
      low_q       <= 1'b0;
      bus_reset_o <= 1'b0;
    end else begin
      bus_reset_o <= present_q &&
                     (greset || (wr_en && wdata[PB_RST] && !ctrl_q[PB_RST]));
      if (soft_rst) begin
        ctrl_q <= present_q ? port_on_attach(PORT_IDLE, low_q) : PORT_IDLE;
      end else begin
        ctrl_q <= ctrl_d;
        if (attach) begin
          present_q <= 1'b1;
          low_q     <= attach_low;
        end else if (detach) begin
          present_q <= 1'b0;
        end
      end
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] sts_flags,  // status bits 4..1
  input  logic [1:0] cause,
  input  logic [3:0] ien,
  output logic       irq_o
);

  logic level;

  always_comb begin
    level = (cause[0] & ien[2]) | (cause[1] & ien[3]) |
            (sts_flags[0] & ien[0]) | (sts_flags[1] & ien[1]) |
            sts_flags[2] | sts_flags[3];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= level;
  end

endmodule

// File: rtl/usbh_regfile.sv
module usbh_regfile
  import usbh_regfile_pkg::*;
#(
  parameter int NUM_PORTS      = 2,
  parameter int FRNUM_W        = 11,
  parameter int BASE_ZERO_BITS = 12,
  parameter int SOF_W          = 8,
  parameter int SOF_RESET      = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_size,
  input  logic [4:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          rd_data_o,
  input  logic [1:0]           cause_set_i,
  input  logic [4:0]           flag_set_i,
  input  logic [NUM_PORTS-1:0] attach_i,
  input  logic [NUM_PORTS-1:0] attach_low_i,
  input  logic [NUM_PORTS-1:0] detach_i,
  output logic                 irq_o,
  output logic                 run_o,
  output logic [FRNUM_W-1:0]   frame_num_o,
  output logic [31:0]          frame_base_o,
  output logic [SOF_W-1:0]     sof_timing_o,
  output logic [NUM_PORTS-1:0] port_bus_reset_o
);

  localparam int PORT_SLOTS = 8;
  localparam int BASE_W     = 32 - BASE_ZERO_BITS;

  logic               wr_byte, wr_word, wr_dword, cmd_hit, soft_rst, greset;
  logic [15:0]        cmd_q;
  logic [5:0]         sts_q, sts_d;
  logic [1:0]         cause_q, cause_d;
  logic [3:0]         ien_q;
  logic [FRNUM_W-1:0] frn_q;
  logic [BASE_W-1:0]  base_q;
  logic [SOF_W-1:0]   sof_q;
  logic [31:0]        rd_mux;
  logic [15:0]        port_ctrl [NUM_PORTS];
  logic [15:0]        slot_val  [PORT_SLOTS];

  assign wr_byte  = bus_wr && (bus_size == SZ_BYTE);
  assign wr_word  = bus_wr && (bus_size == SZ_WORD);
  assign wr_dword = bus_wr && (bus_size == SZ_DWORD);
  assign cmd_hit  = wr_word && (bus_addr == OFS_CMD);
  assign soft_rst = cmd_hit && (bus_wdata[1] || bus_wdata[2]);
  assign greset   = cmd_hit && bus_wdata[2];

  always_comb begin
    sts_d   = sts_q;
    cause_d = cause_q;
    if (wr_word && bus_addr == OFS_STS) begin
      sts_d = sts_q & ~bus_wdata[5:0];
      if (bus_wdata[0]) cause_d = 2'b00;
    end
    sts_d   = sts_d | {flag_set_i, |cause_set_i};
    cause_d = cause_d | cause_set_i;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cmd_q   <= '0;
      sts_q   <= '0;
      cause_q <= '0;
      ien_q   <= '0;
      frn_q   <= '0;
      base_q  <= '0;
      sof_q   <= SOF_W'(SOF_RESET);
    end else begin
      sts_q   <= sts_d;
      cause_q <= cause_d;
      if (cmd_hit) cmd_q <= bus_wdata[15:0];
      if (wr_word && bus_addr == OFS_IEN) ien_q <= bus_wdata[3:0];
      if (wr_word && bus_addr == OFS_FRN && sts_q[5]) frn_q <= bus_wdata[FRNUM_W-1:0];
      if (wr_dword && bus_addr == OFS_BASE) base_q <= bus_wdata[31:BASE_ZERO_BITS];
      if (wr_byte && bus_addr == OFS_SOF) sof_q <= bus_wdata[SOF_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    usbh_root_port u_port (
      .clk         (clk),
      .rst         (rst),
      .soft_rst    (soft_rst),
      .greset      (greset),
      .wr_en       (wr_word && bus_addr[4] && (bus_addr[3:1] == 3'(p))),
      .wdata       (bus_wdata[15:0]),
      .attach      (attach_i[p]),
      .attach_low  (attach_low_i[p]),
      .detach      (detach_i[p]),
      .ctrl_o      (port_ctrl[p]),
      .bus_reset_o (port_bus_reset_o[p])
    );
  end

  for (genvar s = 0; s < PORT_SLOTS; s++) begin : g_slot
    if (s < NUM_PORTS) begin : g_real
      assign slot_val[s] = port_ctrl[s];
    end else begin : g_empty
      assign slot_val[s] = WORD_UNDEF;
    end
  end

  always_comb begin
    rd_mux = 32'hFFFF_FFFF;
    case (bus_size)
      SZ_BYTE:  rd_mux = (bus_addr == OFS_SOF) ? 32'(sof_q) : 32'h0000_00FF;
      SZ_WORD: begin
        if (bus_addr[4]) rd_mux = 32'(slot_val[bus_addr[3:1]]);
        else begin
          case (bus_addr)
            OFS_CMD: rd_mux = 32'(cmd_q);
            OFS_STS: rd_mux = 32'(sts_q);
            OFS_IEN: rd_mux = 32'(ien_q);
            OFS_FRN: rd_mux = 32'(frn_q);
            default: rd_mux = 32'(WORD_UNDEF);
          endcase
        end
      end
      SZ_DWORD: rd_mux = (bus_addr == OFS_BASE) ? frame_base_o : 32'hFFFF_FFFF;
      default:  rd_mux = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data_o <= '0;
    else if (bus_rd) rd_data_o <= rd_mux;
  end

  usbh_irq_gen u_irq (
    .clk       (clk),
    .rst       (rst),
    .sts_flags (sts_q[4:1]),
    .cause     (cause_q),
    .ien       (ien_q),
    .irq_o     (irq_o)
  );

  assign run_o        = cmd_q[0];
  assign frame_num_o  = frn_q;
  assign frame_base_o = {base_q, {BASE_ZERO_BITS{1'b0}}};
  assign sof_timing_o = sof_q;

endmodule

// File: rtl/usbh_regfile_chk.sv
module usbh_regfile_chk #(
  parameter int NUM_PORTS = 2,
  parameter int FRNUM_W   = 11
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic [4:0]           bus_addr,
  input logic [2:0]           sts_hi,  // status bits 5..3
  input logic [3:0]           ien_q,
  input logic                 irq_o,
  input logic                 run_o,
  input logic [FRNUM_W-1:0]   frame_num_o,
  input logic [NUM_PORTS-1:0] port_bus_reset_o
);

  // R7: fatal status bits force the interrupt on the next cycle
  assert_fatal_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (sts_hi[0] || sts_hi[1]) |=> irq_o);

  // R6: no enables and no fatal bits means no interrupt
  assert_quiet_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (ien_q == 4'h0 && !sts_hi[0] && !sts_hi[1]) |=> !irq_o);

  // R2: run flag moves only through a bus write
  assert_run_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(run_o));

  // R8: frame number is locked unless halted (command resets excepted)
  assert_frnum_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (!sts_hi[2] && !(bus_wr && bus_addr == 5'h00)) |=> $stable(frame_num_o));

  // R12: a bus-reset pulse always follows a bus write
  assert_pulse_src_R12: assert property (@(posedge clk) disable iff (rst)
    (port_bus_reset_o != '0) |-> $past(bus_wr));

endmodule

bind usbh_regfile usbh_regfile_chk #(
  .NUM_PORTS (NUM_PORTS),
  .FRNUM_W   (FRNUM_W)
) chk_i (
  .clk              (clk),
  .rst              (rst),
  .bus_wr           (bus_wr),
  .bus_addr         (bus_addr),
  .sts_hi           (sts_q[5:3]),
  .ien_q            (ien_q),
  .irq_o            (irq_o),
  .run_o            (run_o),
  .frame_num_o      (frame_num_o),
  .port_bus_reset_o (port_bus_reset_o)
);

// File: tb/usbh_regfile_tb_top.sv
`timescale 1ns/1ps
module usbh_regfile_tb_top;

  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]    bus_size = 2'b01;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   rd_data_o;
  logic [1:0]    cause_set_i = '0;
  logic [4:0]    flag_set_i = '0;
  logic [NP-1:0] attach_i = '0, attach_low_i = '0, detach_i = '0;
  logic          irq_o, run_o;
  logic [10:0]   frame_num_o;
  logic [31:0]   frame_base_o;
  logic [7:0]    sof_timing_o;
  logic [NP-1:0] port_bus_reset_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  usbh_regfile #(.NUM_PORTS(NP)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sz, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] sz, logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_size = sz; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ev_sts(logic [4:0] f, logic [1:0] c);
    @(negedge clk);
    flag_set_i = f; cause_set_i = c;
    @(negedge clk);
    flag_set_i = '0; cause_set_i = '0;
  endtask

  task automatic ev_port(int p, bit att, bit low, bit det);
    @(negedge clk);
    attach_i[p] = att; attach_low_i[p] = low; detach_i[p] = det;
    @(negedge clk);
    attach_i = '0; attach_low_i = '0; detach_i = '0;
  endtask

  task automatic irq_is(bit exp, string tag);
    @(negedge clk);
    chk(tag, 32'(irq_o), 32'(exp));
  endtask

  // Monitor: scoreboard for read responses
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R14: unexpected read response 0x%0h", rd_data_o);
      end else begin
        chk(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'b01, 5'h00, 32'h0, "R1 cmd");
    rd(2'b01, 5'h02, 32'h0, "R1 status");
    rd(2'b01, 5'h04, 32'h0, "R1 enables");
    rd(2'b10, 5'h08, 32'h0, "R1 base");
    rd(2'b00, 5'h0C, 32'd64, "R1 sof");
    rd(2'b01, 5'h10, 32'h0080, "R1 port0");
    rd(2'b01, 5'h12, 32'h0080, "R1 port1");
    chk("R1 irq", 32'(irq_o), 0);

    // R2 command store
    wr(2'b01, 5'h00, 32'h0041);
    rd(2'b01, 5'h00, 32'h0041, "R2 cmd stored");
    chk("R2 run", 32'(run_o), 1);

    // R4 status set / W1C, R7 fatal
    ev_sts(5'b11111, 2'b01);
    rd(2'b01, 5'h02, 32'h3F, "R4 all set");
    chk("R7 fatal irq", 32'(irq_o), 1);
    wr(2'b01, 5'h02, 32'h0006);
    rd(2'b01, 5'h02, 32'h39, "R4 w1c");
    wr(2'b01, 5'h02, 32'h0018);
    irq_is(0, "R6 no enables");
    rd(2'b01, 5'h02, 32'h21, "R4 w1c fatal");

    // R5/R6 cause latch
    wr(2'b01, 5'h04, 32'h0004);
    irq_is(1, "R6 completion enabled");
    wr(2'b01, 5'h02, 32'h0020);
    irq_is(1, "R5 latch held");
    rd(2'b01, 5'h02, 32'h01, "R5 status after halt clear");
    wr(2'b01, 5'h02, 32'h0001);
    irq_is(0, "R5 latch cleared");
    ev_sts(5'b00000, 2'b10);
    irq_is(0, "R6 short packet not enabled");
    wr(2'b01, 5'h04, 32'h0008);
    irq_is(1, "R6 short packet enabled");
    wr(2'b01, 5'h04, 32'hFFFF);
    rd(2'b01, 5'h04, 32'h000F, "R6 enable width");
    wr(2'b01, 5'h02, 32'h0001);
    irq_is(0, "R5 cleared again");
    wr(2'b01, 5'h04, 32'h0001);
    ev_sts(5'b00001, 2'b00);
    irq_is(1, "R6 error enabled");
    wr(2'b01, 5'h04, 32'h0002);
    irq_is(0, "R6 error disabled");
    ev_sts(5'b00010, 2'b00);
    irq_is(1, "R6 resume enabled");
    wr(2'b01, 5'h02, 32'h0006);
    irq_is(0, "R6 resume cleared");

    // R8 frame number
    wr(2'b01, 5'h06, 32'h0123);
    rd(2'b01, 5'h06, 32'h0, "R8 locked");
    ev_sts(5'b10000, 2'b00);
    wr(2'b01, 5'h06, 32'hFFFF);
    rd(2'b01, 5'h06, 32'h07FF, "R8 halted write");
    chk("R8 frame_num_o", 32'(frame_num_o), 32'h7FF);

    // R9, R10, R14
    wr(2'b10, 5'h08, 32'h12345678);
    rd(2'b10, 5'h08, 32'h12345000, "R9 base");
    wr(2'b00, 5'h0C, 32'h55);
    rd(2'b00, 5'h0C, 32'h55, "R10 sof");
    chk("R10 sof out", 32'(sof_timing_o), 32'h55);
    rd(2'b00, 5'h0D, 32'hFF, "R14 byte undef");
    rd(2'b01, 5'h0A, 32'hFF7F, "R14 word undef");
    rd(2'b10, 5'h00, 32'hFFFFFFFF, "R14 dword undef");
    wr(2'b01, 5'h14, 32'hFFFF);
    rd(2'b01, 5'h14, 32'hFF7F, "R14 slot2");

    // R11 / R12 port writes
    wr(2'b01, 5'h10, 32'hFFFF);
    chk("R12 no device no pulse", 32'(port_bus_reset_o), 0);
    rd(2'b01, 5'h10, 32'hFE84, "R11 merge");
    wr(2'b01, 5'h10, 32'h0000);
    rd(2'b01, 5'h10, 32'h0080, "R11 merge clear");
    ev_port(0, 1, 1, 0);
    rd(2'b01, 5'h10, 32'h0183, "R13 attach low");
    wr(2'b01, 5'h10, 32'h0006);
    rd(2'b01, 5'h10, 32'h0185, "R11 enable and w1c");
    wr(2'b01, 5'h10, 32'h0204);
    chk("R12 pulse", 32'(port_bus_reset_o), 32'b01);
    @(negedge clk);
    chk("R12 pulse width", 32'(port_bus_reset_o), 0);
    wr(2'b01, 5'h10, 32'h0204);
    chk("R12 no repeat", 32'(port_bus_reset_o), 0);
    rd(2'b01, 5'h10, 32'h0385, "R11 reset bit held");
    ev_port(0, 0, 0, 1);
    rd(2'b01, 5'h10, 32'h0389, "R13 detach");
    wr(2'b01, 5'h10, 32'h0008);
    rd(2'b01, 5'h10, 32'h0181, "R11 clear enable change");

    // R13 port1 attach and speed update
    ev_port(1, 1, 0, 0);
    rd(2'b01, 5'h12, 32'h0083, "R13 attach full");
    wr(2'b01, 5'h12, 32'h0002);
    ev_port(1, 1, 1, 0);
    rd(2'b01, 5'h12, 32'h0181, "R13 speed update");

    // R3 global reset
    wr(2'b01, 5'h00, 32'h0004);
    chk("R3 pulse present only", 32'(port_bus_reset_o), 32'b10);
    chk("R2 run after reset", 32'(run_o), 0);
    rd(2'b01, 5'h00, 32'h0, "R2 cmd not stored");
    rd(2'b01, 5'h02, 32'h0, "R2 status reset");
    rd(2'b01, 5'h04, 32'h0, "R2 enables reset");
    rd(2'b01, 5'h06, 32'h0, "R2 frame reset");
    rd(2'b10, 5'h08, 32'h0, "R2 base reset");
    rd(2'b00, 5'h0C, 32'd64, "R2 sof reset");
    rd(2'b01, 5'h10, 32'h0080, "R3 empty port");
    rd(2'b01, 5'h12, 32'h0183, "R3 reattached");

    // R2 controller reset
    wr(2'b01, 5'h00, 32'h0001);
    chk("R2 run set", 32'(run_o), 1);
    wr(2'b01, 5'h00, 32'h0003);
    chk("R2 hc reset no pulse", 32'(port_bus_reset_o), 0);
    chk("R2 hc reset run", 32'(run_o), 0);
    rd(2'b01, 5'h00, 32'h0, "R2 hc reset cmd");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R14: actual %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule